// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Timing Tracker

This block sits beside the command sequencer of an SDRAM controller and keeps a small timing state for every bank. It watches each command the controller issues (activate, read, write or no-op, with a bank number and an auto-precharge flag). From that stream it works out which banks may take an activate, which commands are illegal, and when the data mask must be raised. A read that carries auto-precharge leaves its bank busy for the length of the burst and then for the row-precharge time. A legal read or write to any other bank cuts that burst short and starts the precharge in the same cycle.

The controller uses `act_ok` to gate activates and `cmd_err` as a protocol monitor. It drives the data mask pins from `dqm_req` while a write cuts into read data that is still in flight. The precharge time is captured while reset is held. The CAS latency (2 or 3) and the burst length (4 or 8) are sampled each time they are used, so a bank keeps the burst length it had when its read was accepted.

Top module: `sdram_apt_tracker`

## Requirements
- R1: While reset is held and after it is released, every bit of `act_ok` is 1 and `cmd_err` and `dqm_req` are 0.
- R2: Command codes on `cmd_type` are 0 no-op, 1 activate, 2 read and 3 write. An activate accepted on the edge of cycle T moves the bank to the open state, and its `act_ok` bit is 0 from cycle T+1.
- R3: A read with `cmd_ap`=1 to an open bank in cycle T, with no cut, starts precharge in cycle T+BL. The bank's `act_ok` bit returns to 1 in cycle T+BL+tRP. BL is 8 when `burst_len`=1 and 4 when `burst_len`=0.
- R4: Any activate, read or write to a bank that is in a read with auto-precharge raises `cmd_err` in the next cycle and leaves that bank's timing unchanged.
- R5: A legal read or write in cycle Ti to a bank other than one in a read with auto-precharge (cut allowed up to and including cycle T+BL) starts that bank's precharge in cycle Ti. Its `act_ok` bit returns to 1 in cycle Ti+tRP.
- R6: When a legal write cuts a read with auto-precharge in cycle Tw, `dqm_req` is 1 in cycles Tw+1 to Tw+CL and 0 afterwards unless another cut follows. CL is 3 when `cas_lat`=1 and 2 when `cas_lat`=0.
- R7: A read that cuts a read with auto-precharge does not raise `dqm_req`.
- R8: An activate to a bank whose precharge has not run for tRP cycles raises `cmd_err` and is not accepted. An activate once `act_ok` is back to 1 is accepted.
- R9: tRP is the value of `trp_cfg` sampled while `rst_n` is 0, with 0 taken as 1. Changes to `trp_cfg` after reset have no effect.
- R10: A read or write to a bank that is not open, and an activate to a bank that is open, raise `cmd_err` in the next cycle. A no-op never raises it.
- R11: `cmd_ap` on a write is ignored, and the bank stays open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; asynchronous for state, and `trp_cfg` is captured while it is low |
| trp_cfg | input | TRP_W | Row-precharge time in cycles |
| cas_lat | input | 1 | 0 selects CAS latency 2, 1 selects 3 |
| burst_len | input | 1 | 0 selects burst of 4, 1 selects burst of 8 |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 0 no-op, 1 activate, 2 read, 3 write |
| cmd_bank | input | log2(NUM_BANKS) | Target bank |
| cmd_ap | input | 1 | Auto-precharge request (honoured on reads) |
| act_ok | output | NUM_BANKS | Per-bank flag: an activate would be accepted this cycle |
| cmd_err | output | 1 | Previous cycle's command was illegal |
| dqm_req | output | 1 | Mask request while a write overlaps read data |

## Verification
The bench aims at the cycle on which precharge begins. It covers a cut in the first slot after the read, a cut on the very last burst slot, and the natural end of a burst. A tracker that is off by one cycle there shows `act_ok` rising one cycle early or late, or it raises or drops the mask on a write that lands on the boundary. Activates during the tRP window check that a premature activate is refused and that an activate exactly on the ready cycle is taken. A tracker that used the live `trp_cfg`, or took 0 literally, would hang a bank or free it too early. A long random mix of commands, burst lengths and latencies is compared against a behavioural model every cycle. That mix catches a tracker that cuts the target bank itself, or that reads the burst length at the wrong time.

// File: rtl/sdram_apt_pkg.sv
package sdram_apt_pkg;

   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_ACT = 2'd1,
      CMD_RD  = 2'd2,
      CMD_WR  = 2'd3
   } apt_cmd_e;

   typedef enum logic [1:0] {
      BK_IDLE   = 2'd0,
      BK_OPEN   = 2'd1,
      BK_RDAP   = 2'd2,
      BK_PRECH  = 2'd3
   } apt_bank_e;

endpackage

// File: rtl/sdram_apt_bank.sv
module sdram_apt_bank
   import sdram_apt_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act,
   input  logic             do_rdap,
   input  logic             do_cut,
   input  logic [CNT_W-1:0] burst_cyc,
   input  logic [CNT_W-1:0] trp_cyc,
   output apt_bank_e        st,
   output logic             ready
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= BK_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            BK_IDLE: begin
               if (do_act) st <= BK_OPEN;
            end
            BK_OPEN: begin
               if (do_rdap) begin
                  st  <= BK_RDAP;
                  cnt <= burst_cyc - CNT_W'(1);
               end
            end
            BK_RDAP: begin
               if (do_cut || cnt == '0) begin
                  st  <= BK_PRECH;
                  cnt <= trp_cyc - CNT_W'(1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            BK_PRECH: begin
               if (do_act)            st  <= BK_OPEN;
               else if (cnt == '0)    st  <= BK_IDLE;
               else                   cnt <= cnt - CNT_W'(1);
            end
            default: st <= BK_IDLE;
         endcase
      end
   end

   assign ready = (st == BK_IDLE) || (st == BK_PRECH && cnt == '0);

endmodule

// File: rtl/sdram_apt_dqm.sv
module sdram_apt_dqm #(
   parameter int CL_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [CL_W-1:0] cl_cyc,
   output logic            dqm_req
);

   logic [CL_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           left <= '0;
      else if (fire)        left <= cl_cyc;
      else if (left != '0)  left <= left - CL_W'(1);
   end

   assign dqm_req = (left != '0);

endmodule

// File: rtl/sdram_apt_tracker.sv
module sdram_apt_tracker
   import sdram_apt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int TRP_W     = 4,
   parameter int BL_SHORT  = 4,
   parameter int BL_LONG   = 8,
   parameter int CL_LOW    = 2,
   parameter int CL_HIGH   = 3,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TRP_W-1:0]     trp_cfg,
   input  logic                 cas_lat,
   input  logic                 burst_len,
   input  logic                 cmd_valid,
   input  logic [1:0]           cmd_type,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   output logic [NUM_BANKS-1:0] act_ok,
   output logic                 cmd_err,
   output logic                 dqm_req
);

   localparam int BL_W  = $clog2(BL_LONG + 1);
   localparam int CNT_W = (TRP_W > BL_W) ? TRP_W : BL_W;
   localparam int CL_W  = $clog2(CL_HIGH + 1);

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (BL_SHORT < 1 || BL_LONG <= BL_SHORT) begin : g_bad_bl
      $error("burst lengths must satisfy 1 <= BL_SHORT < BL_LONG");
   end
   if (CL_LOW < 1 || CL_HIGH <= CL_LOW) begin : g_bad_cl
      $error("CAS latencies must satisfy 1 <= CL_LOW < CL_HIGH");
   end
   if (TRP_W < 1) begin : g_bad_trp
      $error("TRP_W must be at least 1");
   end

   logic [TRP_W-1:0] trp_q;
   always_ff @(posedge clk) begin
      if (!rst_n) trp_q <= (trp_cfg == '0) ? TRP_W'(1) : trp_cfg;
   end

   logic [CNT_W-1:0] burst_cyc, trp_cyc;
   logic [CL_W-1:0]  cl_cyc;
   assign burst_cyc = burst_len ? CNT_W'(BL_LONG) : CNT_W'(BL_SHORT);
   assign trp_cyc   = CNT_W'(trp_q);
   assign cl_cyc    = cas_lat ? CL_W'(CL_HIGH) : CL_W'(CL_LOW);

   apt_cmd_e               cmd;
   logic [NUM_BANKS-1:0][1:0] st_vec;
   logic [NUM_BANKS-1:0]   rdap_vec;
   logic [NUM_BANKS-1:0]   sel_oh;
   apt_bank_e              sel_st;
   logic                   legal_act, legal_rw, illegal, dqm_fire;

   assign cmd    = apt_cmd_e'(cmd_type);
   assign sel_oh = NUM_BANKS'(1) << cmd_bank;
   assign sel_st = apt_bank_e'(st_vec[cmd_bank]);

   assign legal_act = cmd_valid && cmd == CMD_ACT && act_ok[cmd_bank];
   assign legal_rw  = cmd_valid && (cmd == CMD_RD || cmd == CMD_WR) && sel_st == BK_OPEN;
   assign illegal   = cmd_valid && cmd != CMD_NOP && !legal_act && !legal_rw;
   assign dqm_fire  = legal_rw && cmd == CMD_WR && (|(rdap_vec & ~sel_oh));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      apt_bank_e st_b;
      sdram_apt_bank #(.CNT_W(CNT_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .do_act    (legal_act && sel_oh[b]),
         .do_rdap   (legal_rw && sel_oh[b] && cmd == CMD_RD && cmd_ap),
         .do_cut    (legal_rw && !sel_oh[b]),
         .burst_cyc (burst_cyc),
         .trp_cyc   (trp_cyc),
         .st        (st_b),
         .ready     (act_ok[b])
      );
      assign st_vec[b]   = st_b;
      assign rdap_vec[b] = (st_b == BK_RDAP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_err <= 1'b0;
      else        cmd_err <= illegal;
   end

   sdram_apt_dqm #(.CL_W(CL_W)) u_dqm (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (dqm_fire),
      .cl_cyc  (cl_cyc),
      .dqm_req (dqm_req)
   );

endmodule

// File: rtl/sdram_apt_chk.sv
module sdram_apt_chk
   import sdram_apt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cmd_valid,
   input logic [1:0]                cmd_type,
   input logic [BANK_W-1:0]         cmd_bank,
   input logic [NUM_BANKS-1:0]      act_ok,
   input logic                      cmd_err,
   input logic                      dqm_req,
   input logic [NUM_BANKS-1:0][1:0] st_vec
);

   logic [NUM_BANKS-1:0] rd_vec;
   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) rd_vec[b] = (st_vec[b] == BK_RDAP);
   end

   logic tgt_open, is_rw;
   assign tgt_open = (st_vec[cmd_bank] == BK_OPEN);
   assign is_rw    = cmd_valid && cmd_type[1];

   a_r10_no_err_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_type != 2'd0) |=> !cmd_err);

   a_r4_busy_bank_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_type != 2'd0 && st_vec[cmd_bank] == BK_RDAP) |=> cmd_err);

   a_r8_blocked_activate: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_type == 2'd1 && !act_ok[cmd_bank]) |=> cmd_err);

   a_r2_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_type == 2'd1 && act_ok[cmd_bank])
      |=> (st_vec[$past(cmd_bank)] == BK_OPEN && !cmd_err));

   a_r3_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_vec));

   a_r6_write_cut_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && cmd_type[0] && tgt_open && (|rd_vec)) |=> dqm_req);

   a_r7_read_cut_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && !cmd_type[0] && !dqm_req) |=> !dqm_req);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cut
      a_r5_cut_starts_precharge: assert property (@(posedge clk) disable iff (!rst_n)
         (is_rw && tgt_open && cmd_bank != BANK_W'(b) && st_vec[b] == BK_RDAP)
         |=> (st_vec[b] == BK_PRECH || act_ok[b]));
   end

endmodule

bind sdram_apt_tracker sdram_apt_chk #(.NUM_BANKS(NUM_BANKS)) u_apt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_type  (cmd_type),
   .cmd_bank  (cmd_bank),
   .act_ok    (act_ok),
   .cmd_err   (cmd_err),
   .dqm_req   (dqm_req),
   .st_vec    (st_vec)
);

// File: tb/sdram_apt_tracker_tb_top.sv
module sdram_apt_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] trp_cfg = 4'd3;
   logic       cas_lat = 1'b0;
   logic       burst_len = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_type = 2'd0;
   logic [1:0] cmd_bank = 2'd0;
   logic       cmd_ap = 1'b0;
   logic [NB-1:0] act_ok;
   logic       cmd_err;
   logic       dqm_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_apt_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .trp_cfg(trp_cfg), .cas_lat(cas_lat),
      .burst_len(burst_len), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
      .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .act_ok(act_ok),
      .cmd_err(cmd_err), .dqm_req(dqm_req)
   );

   int    errors = 0;
   int    checks = 0;
   string phase = "R1 reset";

   // behavioural model: 0 idle, 1 open, 2 read-ap, 3 precharging
   int mst[NB];
   int mt0[NB];
   int mbl[NB];
   int m_trp;
   int m_dqm;
   bit m_err;
   int cyc;

   function automatic void model_reset(int trp_val);
      for (int b = 0; b < NB; b++) begin mst[b] = 0; mt0[b] = 0; mbl[b] = 4; end
      m_trp = (trp_val == 0) ? 1 : trp_val;
      m_dqm = 0;
      m_err = 1'b0;
   endfunction

   function automatic void normalize(int c);
      for (int b = 0; b < NB; b++) begin
         if (mst[b] == 2 && c > mt0[b] + mbl[b]) begin mst[b] = 3; mt0[b] = mt0[b] + mbl[b]; end
         if (mst[b] == 3 && c >= mt0[b] + m_trp) mst[b] = 0;
      end
   endfunction

   task automatic check_bit(string what, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: %s got %b expected %b (cycle %0d)", phase, what, got, exp, cyc);
      end
   endtask

   task automatic compare();
      for (int b = 0; b < NB; b++)
         check_bit($sformatf("act_ok[%0d]", b), act_ok[b], mst[b] == 0);
      check_bit("cmd_err", cmd_err, m_err);
      check_bit("dqm_req", dqm_req, m_dqm > 0);
   endtask

   function automatic void model_cmd(int ty, int bk, bit ap, int c);
      bit legal = 1'b0;
      bit cut = 1'b0;
      if (ty == 1) begin
         legal = (mst[bk] == 0);
         if (legal) mst[bk] = 1;
      end else if (ty >= 2) begin
         legal = (mst[bk] == 1);
         if (legal) begin
            for (int o = 0; o < NB; o++)
               if (o != bk && mst[o] == 2) begin mst[o] = 3; mt0[o] = c; cut = 1'b1; end
            if (ty == 2 && ap) begin mst[bk] = 2; mt0[bk] = c; mbl[bk] = burst_len ? 8 : 4; end
         end
      end
      m_err = (ty != 0) && !legal;
      if (cut && ty == 3) m_dqm = cas_lat ? 3 : 2;
      else if (m_dqm > 0) m_dqm--;
   endfunction

   task automatic step(int ty, int bk, bit ap);
      normalize(cyc);
      compare();
      cmd_valid = (ty != 0);
      cmd_type  = 2'(ty);
      cmd_bank  = 2'(bk);
      cmd_ap    = ap;
      model_cmd(ty, bk, ap, cyc);
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 1'b0);
   endtask

   task automatic do_reset(int trp_val);
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0; cmd_type = 2'd0;
      trp_cfg = 4'(trp_val);
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      phase = "R1 reset";
      for (int b = 0; b < NB; b++) check_bit("act_ok in reset", act_ok[b], 1'b1);
      check_bit("cmd_err in reset", cmd_err, 1'b0);
      check_bit("dqm_req in reset", dqm_req, 1'b0);
      model_reset(trp_val);
      rst_n = 1'b1;
      cyc = 100;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
   end

   initial begin
      do_reset(3);
      trp_cfg = 4'd12;                      // R9: ignored after reset
      phase = "R1 after reset"; idle(2);

      phase = "R2 activate"; step(1, 0, 0); idle(1);

      phase = "R3 natural precharge BL4";
      step(2, 0, 1); idle(9);

      phase = "R10 illegal rd and act"; step(2, 3, 0); step(3, 2, 0);
      step(1, 0, 0); step(1, 0, 0); idle(1);

      phase = "R11 ap on write ignored"; step(3, 0, 1); idle(2); step(2, 0, 0); idle(1);

      phase = "R4 same bank during read-ap";
      step(2, 0, 1); step(3, 0, 0); step(1, 0, 0); step(2, 0, 1); idle(8);
      step(1, 0, 0);

      phase = "R8 activate during precharge";
      step(2, 0, 1); idle(4); step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); idle(1);

      phase = "R5 R6 write cut BL8 CL3";
      burst_len = 1'b1; cas_lat = 1'b1;
      step(1, 1, 0); step(2, 0, 1); idle(2); step(3, 1, 0); idle(7);

      phase = "R6 write cut first slot CL2";
      burst_len = 1'b0; cas_lat = 1'b0;
      step(1, 0, 0); step(2, 0, 1); step(3, 1, 0); idle(6);

      phase = "R7 read cut no mask";
      step(1, 2, 0); step(2, 2, 1); idle(1); step(2, 1, 0); idle(5);

      phase = "R6 cut on last burst slot";
      step(1, 2, 0); step(2, 2, 1); idle(3); step(3, 1, 0); idle(6);

      phase = "R3 natural precharge BL8";
      burst_len = 1'b1;
      step(1, 0, 0); step(2, 0, 1); idle(13);

      do_reset(0);
      trp_cfg = 4'd9;
      phase = "R9 zero trp means one";
      burst_len = 1'b0;
      step(1, 0, 0); step(2, 0, 1); idle(7); step(1, 0, 0); idle(1);

      do_reset(5);
      phase = "R4 R5 R6 R8 random mix";
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 16) == 0) begin
            burst_len = 1'($urandom);
            cas_lat   = 1'($urandom);
         end
         step(int'($urandom % 4), int'($urandom % NB), 1'($urandom));
      end
      idle(2);

      summary();
      $finish;
   end

endmodule